// File: doc/BRIEF.md
# Double-Buffered Serial Receive Host Interface

This block sits between a line receiver and a host controller. Received bits arrive one per `bit_valid_i` pulse while `carrier_i` is high. The block packs them into bytes, least significant bit first, and stores each byte in one of two eight-byte buffers. Both buffers live in a small shared store that the host can read at any time.

Each buffer has a status word. A status word of zero means the buffer belongs to the block and may be filled. A nonzero status word means the buffer is held by the host, and the value is the byte count. The host hands a buffer back by writing zero to its status word. When a buffer fills up, or when the carrier drops with a partly filled buffer, the block writes the byte count into the status word and pulses the receive interrupt. It then moves on to the other buffer.

When both buffers are held and line bits keep arriving, those bits are thrown away. The error interrupt pulses once for each such overrun episode. After reset both buffers are held, so the host must release them before the carrier comes up.

Top module: `rx_pingpong_host`

## Requirements
- R1: After reset, both status words read 8 (held), every data byte reads 0, and both interrupt outputs are low.
- R2: A host write of value 0 to a status word (`host_wsel_i` 0 or 1) makes that word read 0. A host write of any nonzero value leaves both status words unchanged.
- R3: A bit is taken only on a clock edge where both `carrier_i` and `bit_valid_i` are high. Bits fill a byte from bit 0 upward. A completed byte is stored at the next free index of the buffer being filled.
- R4: When the 8th byte of a buffer is stored, its status word becomes 8. `rx_irq_o` is high for exactly the one cycle after the edge that took the final bit.
- R5: With both buffers released after reset, the first byte goes to buffer 0.
- R6: After a buffer is closed, filling continues in the other buffer, so the buffers alternate.
- R7: A bit that arrives while both status words are nonzero is discarded and does not enter any byte. `err_irq_o` pulses for one cycle on the first such bit of an episode. An episode ends when a buffer is released.
- R8: As soon as one held buffer is released during an overrun, the following bits fill that buffer from index 0.
- R9: When `carrier_i` falls and the current buffer holds at least one byte, that buffer is closed with its byte count, and `rx_irq_o` pulses one cycle later. If the buffer holds no byte, nothing is closed and no interrupt is raised. The bits of an unfinished byte are dropped in both cases.
- R10: The host read address map is fixed:
  - addresses `b*8 + i` (0 to 15) return byte `i` of buffer `b`;
  - address 16 returns status word 0 and address 17 returns status word 1, zero-extended to 8 bits;
  - addresses 18 to 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_i | input | 1 | Carrier present; received bits are taken only while high |
| bit_valid_i | input | 1 | One-cycle strobe marking a received bit |
| bit_i | input | 1 | Received bit value |
| host_wr_i | input | 1 | Host write strobe to a status word |
| host_wsel_i | input | 1 | Selects status word 0 or 1 for the write |
| host_wdata_i | input | 8 | Write value; only zero has an effect |
| host_raddr_i | input | 5 | Host read address |
| host_rdata_o | output | 8 | Combinational read data |
| rx_irq_o | output | 1 | One-cycle pulse when a buffer is closed |
| err_irq_o | output | 1 | One-cycle pulse at the start of an overrun episode |

## Verification
A wrong buffer selector shows up at the ports as bytes landing in the wrong half of the read map. It also shows up as a status word for the wrong buffer taking the count. Either is visible on the first status read after the close, within a cycle of `rx_irq_o`.

A wrong byte index or bit counter corrupts the stored bytes, or makes the close interrupt come early or late. The bench checks that interrupt on the exact cycle after the final bit.

Wrong overrun tracking shows up as a repeated or missing `err_irq_o` pulse. It also shows up as leftover bits shifting the first byte stored after the release.

// File: rtl/rxdb_pkg.sv
package rxdb_pkg;

  // Choose the buffer to fill: stay on the current one if it is free,
  // otherwise take the other one.
  function automatic logic pick_buffer(logic [1:0] held, logic cur);
    return held[cur] ? ~cur : cur;
  endfunction

  function automatic logic is_last_slot(int idx, int depth);
    return idx == depth - 1;
  endfunction

  function automatic int store_index(logic bsel, int idx, int depth);
    return (bsel ? depth : 0) + idx;
  endfunction

endpackage

// File: rtl/rxdb_assembler.sv
module rxdb_assembler #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic              byte_ready_o,
  output logic [BYTE_W-1:0] byte_o
);

  logic [BYTE_W-2:0] part_q;
  logic [CNT_W-1:0]  cnt_q;

  // The new bit enters at the top; earlier bits move down, so the first
  // bit ends up in bit 0.
  assign byte_o       = {bit_i, part_q};
  assign byte_ready_o = shift_en_i && (cnt_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (shift_en_i) begin
      part_q <= byte_o[BYTE_W-1:1];
      cnt_q  <= byte_ready_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rxdb_ctrl.sv
module rxdb_ctrl
  import rxdb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int STAT_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_i,
  input  logic              bit_valid_i,
  input  logic              host_rel_i,
  input  logic              host_rel_sel_i,
  input  logic              byte_ready_i,
  output logic              bit_accept_o,
  output logic              wr_en_o,
  output logic              wr_sel_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [STAT_W-1:0] stat0_o,
  output logic [STAT_W-1:0] stat1_o,
  output logic              rx_irq_o,
  output logic              err_irq_o,
  output logic              full_close_o,
  output logic              short_close_o,
  output logic              discard_o,
  output logic              both_held_o
);

  logic [STAT_W-1:0] stat_q [2];
  logic              cur_q, carrier_q, ovr_q, rx_irq_q, err_irq_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        held;
  logic              bit_seen, sel, drop;

  assign held         = {stat_q[1] != '0, stat_q[0] != '0};
  assign both_held_o  = &held;
  assign bit_seen     = carrier_i && bit_valid_i;
  assign bit_accept_o = bit_seen && !both_held_o;
  assign discard_o    = bit_seen && both_held_o;
  assign sel          = pick_buffer(held, cur_q);
  assign drop         = carrier_q && !carrier_i;

  assign wr_en_o       = byte_ready_i;
  assign wr_sel_o      = sel;
  assign wr_idx_o      = idx_q;
  assign full_close_o  = wr_en_o && is_last_slot(int'(idx_q), DEPTH);
  assign short_close_o = drop && (idx_q != '0);

  assign stat0_o   = stat_q[0];
  assign stat1_o   = stat_q[1];
  assign rx_irq_o  = rx_irq_q;
  assign err_irq_o = err_irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q[0] <= STAT_W'(DEPTH);
      stat_q[1] <= STAT_W'(DEPTH);
      cur_q     <= 1'b0;
      idx_q     <= '0;
      carrier_q <= 1'b0;
      ovr_q     <= 1'b0;
      rx_irq_q  <= 1'b0;
      err_irq_q <= 1'b0;
    end else begin
      carrier_q <= carrier_i;
      rx_irq_q  <= full_close_o || short_close_o;
      err_irq_q <= discard_o && !ovr_q;
      if (!both_held_o)   ovr_q <= 1'b0;
      else if (discard_o) ovr_q <= 1'b1;

      // The block only closes a free buffer, so a host release never
      // targets the same word in the same cycle with a different result.
      if (host_rel_i) stat_q[host_rel_sel_i] <= '0;

      if (full_close_o) begin
        stat_q[sel] <= STAT_W'(DEPTH);
        cur_q       <= ~sel;
        idx_q       <= '0;
      end else if (wr_en_o) begin
        cur_q <= sel;
        idx_q <= idx_q + IDX_W'(1);
      end else if (short_close_o) begin
        stat_q[cur_q] <= STAT_W'(idx_q);
        cur_q         <= ~cur_q;
        idx_q         <= '0;
      end
    end
  end

endmodule

// File: rtl/rxdb_store.sv
module rxdb_store
  import rxdb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  parameter int HOST_W = 8,
  parameter int STAT_W = 4,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] stat0_i,
  input  logic [STAT_W-1:0] stat1_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [HOST_W-1:0] rdata_o
);

  localparam int SLOTS = 2 * DEPTH;

  logic [BYTE_W-1:0] mem_q [SLOTS];
  int                waddr;

  assign waddr = store_index(wr_sel_i, int'(wr_idx_i), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < SLOTS; i++)
        if (waddr == i) mem_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < SLOTS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = HOST_W'(mem_q[i]);
    if (raddr_i == ADDR_W'(SLOTS))     rdata_o = HOST_W'(stat0_i);
    if (raddr_i == ADDR_W'(SLOTS + 1)) rdata_o = HOST_W'(stat1_i);
  end

endmodule

// File: rtl/rx_pingpong_host.sv
module rx_pingpong_host #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  parameter int HOST_W = 8,
  localparam int ADDR_W = $clog2(2 * DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              host_wr_i,
  input  logic              host_wsel_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  input  logic [ADDR_W-1:0] host_raddr_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);

  localparam int STAT_W = $clog2(DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Named internal events, brought out for the bound checker.
  logic              bit_accept, byte_ready, wr_en, wr_sel, host_rel;
  logic              ev_full_close, ev_short_close, ev_discard, both_held;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] byte_val;
  logic [STAT_W-1:0] stat0, stat1;

  assign host_rel = host_wr_i && (host_wdata_i == '0);

  rxdb_assembler #(.BYTE_W(BYTE_W)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (!carrier_i),
    .shift_en_i   (bit_accept),
    .bit_i        (bit_i),
    .byte_ready_o (byte_ready),
    .byte_o       (byte_val)
  );

  rxdb_ctrl #(.DEPTH(DEPTH), .STAT_W(STAT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .carrier_i      (carrier_i),
    .bit_valid_i    (bit_valid_i),
    .host_rel_i     (host_rel),
    .host_rel_sel_i (host_wsel_i),
    .byte_ready_i   (byte_ready),
    .bit_accept_o   (bit_accept),
    .wr_en_o        (wr_en),
    .wr_sel_o       (wr_sel),
    .wr_idx_o       (wr_idx),
    .stat0_o        (stat0),
    .stat1_o        (stat1),
    .rx_irq_o       (rx_irq_o),
    .err_irq_o      (err_irq_o),
    .full_close_o   (ev_full_close),
    .short_close_o  (ev_short_close),
    .discard_o      (ev_discard),
    .both_held_o    (both_held)
  );

  rxdb_store #(
    .DEPTH(DEPTH), .BYTE_W(BYTE_W), .HOST_W(HOST_W),
    .STAT_W(STAT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_idx_i  (wr_idx),
    .wr_data_i (byte_val),
    .stat0_i   (stat0),
    .stat1_i   (stat1),
    .raddr_i   (host_raddr_i),
    .rdata_o   (host_rdata_o)
  );

endmodule

// File: rtl/rxdb_checker.sv
module rxdb_checker #(
  parameter int DEPTH  = 8,
  parameter int HOST_W = 8,
  localparam int STAT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              carrier_i,
  input logic              bit_valid_i,
  input logic              host_wr_i,
  input logic              host_wsel_i,
  input logic [HOST_W-1:0] host_wdata_i,
  input logic              rx_irq_o,
  input logic              err_irq_o,
  input logic              full_close,
  input logic              short_close,
  input logic              discard,
  input logic              both_held,
  input logic [STAT_W-1:0] stat0,
  input logic [STAT_W-1:0] stat1
);

  p_release0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_wdata_i == '0 && !host_wsel_i && stat0 != '0) |=> stat0 == '0);

  p_release1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_wdata_i == '0 && host_wsel_i && stat1 != '0) |=> stat1 == '0);

  p_nonzero_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_wdata_i != '0 && !full_close && !short_close)
      |=> ($stable(stat0) && $stable(stat1)));

  p_full_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_close |=> (rx_irq_o && (stat0 == STAT_W'(DEPTH) || stat1 == STAT_W'(DEPTH))));

  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |=> !rx_irq_o);

  p_discard_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> (both_held && carrier_i && bit_valid_i));

  p_err_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |=> !err_irq_o);

  p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq_o) |-> $past(discard));

  p_short_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_close |-> (!carrier_i && !full_close));

  p_short_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_close |=> rx_irq_o);

endmodule

bind rx_pingpong_host rxdb_checker #(.DEPTH(DEPTH), .HOST_W(HOST_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .carrier_i    (carrier_i),
  .bit_valid_i  (bit_valid_i),
  .host_wr_i    (host_wr_i),
  .host_wsel_i  (host_wsel_i),
  .host_wdata_i (host_wdata_i),
  .rx_irq_o     (rx_irq_o),
  .err_irq_o    (err_irq_o),
  .full_close   (ev_full_close),
  .short_close  (ev_short_close),
  .discard      (ev_discard),
  .both_held    (both_held),
  .stat0        (stat0),
  .stat1        (stat1)
);

// File: tb/rx_pingpong_host_bench.sv
module rx_pingpong_host_bench;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0;
  logic       host_wr_i = 1'b0, host_wsel_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic [4:0] host_raddr_i = '0;
  logic [7:0] host_rdata_o;
  logic       rx_irq_o, err_irq_o;

  int n_chk = 0, n_fail = 0;
  int rx_seen = 0, err_seen = 0;
  int exp_rx = 0;
  bit done = 0;
  logic [7:0] exp_bytes [2][DEPTH];

  always #2.5 clk = ~clk;

  rx_pingpong_host u_rx_pingpong_host (
    .clk(clk), .rst_n(rst_n), .carrier_i(carrier_i), .bit_valid_i(bit_valid_i),
    .bit_i(bit_i), .host_wr_i(host_wr_i), .host_wsel_i(host_wsel_i),
    .host_wdata_i(host_wdata_i), .host_raddr_i(host_raddr_i),
    .host_rdata_o(host_rdata_o), .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o)
  );

  always @(negedge clk) begin
    if (rst_n && rx_irq_o)  rx_seen++;
    if (rst_n && err_irq_o) err_seen++;
  end

  // Expected read address for byte k of buffer b (R10).
  function automatic logic [4:0] byte_addr(int b, int k);
    return 5'(b * DEPTH + k);
  endfunction

  function automatic logic [4:0] stat_addr(int b);
    return 5'(2 * DEPTH + b);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk);
    host_raddr_i = a;
    #0.5;
    v = int'(host_rdata_o);
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr_i = 1'b1; host_wsel_i = sel; host_wdata_i = d;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic set_carrier(input logic c);
    @(negedge clk);
    carrier_i = c;
  endtask

  // Idle cycles with bit_i toggling and bit_valid_i low (R3).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid_i = 1'b0;
      bit_i = 1'($urandom);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid_i = 1'b1; bit_i = b;
    @(negedge clk);
    bit_valid_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit gaps);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (gaps && i < 7) idle(int'($urandom % 3));
    end
  endtask

  task automatic fill(input int b, input int n, input bit gaps);
    for (int k = 0; k < n; k++) begin
      exp_bytes[b][k] = 8'($urandom);
      send_byte(exp_bytes[b][k], gaps);
    end
  endtask

  task automatic check_bytes(input int b, input int n, input string req);
    int v;
    for (int k = 0; k < n; k++) begin
      rd(byte_addr(b, k), v);
      check(req, v, int'(exp_bytes[b][k]));
    end
  endtask

  task automatic check_stat(input int b, input int exp, input string req);
    int v;
    rd(stat_addr(b), v);
    check(req, v, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int v, a;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_stat(0, DEPTH, "R1 status0 after reset");
    check_stat(1, DEPTH, "R1 status1 after reset");
    rd(byte_addr(1, 3), v);
    check("R1 data after reset", v, 0);
    check("R1 rx_irq after reset", int'(rx_irq_o), 0);
    check("R1 err_irq after reset", int'(err_irq_o), 0);

    // R2: nonzero write ignored, zero write releases
    host_write(1'b0, 8'h05);
    check_stat(0, DEPTH, "R2 nonzero write ignored");
    host_write(1'b0, 8'h00);
    host_write(1'b1, 8'h00);
    check_stat(0, 0, "R2 release buffer 0");
    check_stat(1, 0, "R2 release buffer 1");

    // R3: bits with carrier low are ignored
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    set_carrier(1'b1);

    // R5, R3, R4: first buffer is buffer 0; check irq cycle on last bit
    fill(0, DEPTH - 1, 1'b1);
    exp_bytes[0][DEPTH-1] = 8'hA5;
    for (int i = 0; i < 7; i++) send_bit(exp_bytes[0][DEPTH-1][i]);
    check("R4 no irq before last bit", int'(rx_irq_o), 0);
    send_bit(exp_bytes[0][DEPTH-1][7]);
    check("R4 irq one cycle after last bit", int'(rx_irq_o), 1);
    @(negedge clk);
    check("R4 irq is a single pulse", int'(rx_irq_o), 0);
    exp_rx++;
    check_stat(0, DEPTH, "R4 status0 full count");
    check_stat(1, 0, "R5 buffer 1 untouched");
    check_bytes(0, DEPTH, "R3 R5 buffer 0 bytes");

    // R6: alternate into buffer 1
    fill(1, DEPTH, 1'b0);
    idle(1);
    exp_rx++;
    check_stat(1, DEPTH, "R6 status1 full count");
    check_bytes(1, DEPTH, "R6 buffer 1 bytes");
    check("R6 rx irq count", rx_seen, exp_rx);

    // R7: overrun with both held, one pulse per episode
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    idle(1);
    check("R7 error pulse on overrun", err_seen, 1);
    for (int i = 0; i < 10; i++) send_bit(1'($urandom));
    idle(1);
    check("R7 one pulse per episode", err_seen, 1);

    // R8: release buffer 0, filling resumes at index 0 with fresh bits
    host_write(1'b0, 8'h00);
    fill(0, DEPTH, 1'b1);
    idle(1);
    exp_rx++;
    check_stat(0, DEPTH, "R8 refilled buffer 0");
    check_bytes(0, DEPTH, "R8 R7 discarded bits absent");

    // R7: new episode gives a new pulse
    send_bit(1'b0);
    idle(1);
    check("R7 second episode pulse", err_seen, 2);

    // R9: carrier drop closes partial buffer 1 with count 3
    host_write(1'b1, 8'h00);
    fill(1, 3, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    set_carrier(1'b0);
    idle(2);
    exp_rx++;
    check_stat(1, 3, "R9 partial close count");
    check_bytes(1, 3, "R9 partial bytes");
    check("R9 irq on partial close", rx_seen, exp_rx);

    // R9: drop with no whole byte closes nothing
    host_write(1'b0, 8'h00);
    set_carrier(1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    set_carrier(1'b0);
    idle(2);
    check_stat(0, 0, "R9 empty drop leaves status");
    check("R9 no irq on empty drop", rx_seen, exp_rx);
    set_carrier(1'b1);
    fill(0, 2, 1'b1);
    set_carrier(1'b0);
    idle(2);
    exp_rx++;
    check_stat(0, 2, "R9 count after dropped bits");
    check_bytes(0, 2, "R9 unfinished byte dropped");

    // R10: unmapped addresses read zero
    a = 2 * DEPTH + 2 + int'($urandom % 14);
    rd(5'(a), v);
    check("R10 unmapped read", v, 0);

    // Random rounds: release both, fill k bytes, drop carrier (R6, R9)
    a = 1;
    for (int r = 0; r < 12; r++) begin
      int k;
      k = 1 + int'($urandom % DEPTH);
      host_write(1'b0, 8'h00);
      host_write(1'b1, 8'h00);
      set_carrier(1'b1);
      fill(a, k, 1'($urandom));
      set_carrier(1'b0);
      idle(2);
      exp_rx++;
      check_stat(a, k, "R6 R9 random round count");
      check_stat(1 - a, 0, "R6 other buffer free");
      check_bytes(a, k, "R3 random round bytes");
      a = 1 - a;
    end
    check("R4 R9 total rx irqs", rx_seen, exp_rx);
    check("R7 total error pulses", err_seen, 2);

    done = 1;
    summary();
    $finish;
  end

endmodule